// File: doc/BRIEF.md
# Serial Byte-Burst Register Access Slave

This block is a serial-peripheral slave that lets an external host reach a small internal address space one byte at a time. Chip select frames each transfer. The host first sends a command byte and then a start address byte. After that it moves any number of data bytes, and each byte uses the next address in turn. The slave runs the inner side of a plain register-file port: an address, write data, a one-cycle write strobe, a one-cycle read strobe, and read data that returns one cycle after the read strobe.

A write burst is full duplex. As each data byte is written, the slave sends back on MISO the output value stored at the address written just before it. A single burst can therefore load fresh input and collect the previous result at the same time. A read burst returns stored values from consecutive addresses while the host clocks dummy bytes. The three serial inputs are brought into the system clock domain by a synchroniser whose depth is a parameter, so SCK must be several system clocks slower.

Top module: `spi_mem_slave`

## Requirements
- R1: The serial link uses clock-idle-low timing. MOSI is sampled on the rising SCK edge, MISO changes only after a falling SCK edge or between bytes, and every byte is sent most significant bit first.
- R2: The first byte after chip select goes low is a command. The value 0x00 starts a read burst and the value 0x40 starts a write burst.
- R3: The second byte is the start address. Each later data byte uses the address one above the byte before it.
- R4: In a write burst, each complete data byte produces exactly one write strobe carrying that byte and its address. A burst ends only when chip select goes high.
- R5: In a write burst, the byte returned while address A+1 is written holds the stored output of address A. The byte returned with the first data byte is 0x00. Every write strobe is followed in the next cycle by a read strobe at the same address.
- R6: In a read burst, each dummy byte returns the stored output of the next address, starting at the start address. The command and address bytes return 0x00.
- R7: Addresses wrap from 0xFF to 0x00 in both burst directions.
- R8: A command byte other than the two defined values makes the slave ignore the rest of the burst. No strobe is issued and MISO returns 0x00.
- R9: If chip select goes high in the middle of a byte, the partial byte is discarded and nothing is written for it. The next burst starts again with a command byte.
- R10: Write and read strobes each last exactly one system clock cycle and are never active in the same cycle.
- R11: After reset, and while chip select is high, MISO is 0 and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select; frames each burst |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| rf_addr | output | ADDR_W | Register-file address |
| rf_wdata | output | WORD_W | Register-file write data |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_re | output | 1 | Register-file read strobe, one cycle |
| rf_rdata | input | WORD_W | Register-file read data, valid the cycle after rf_re |

## Verification
The assertions check the following on every cycle:
- both strobes are single-cycle pulses and never overlap;
- a strobe only appears while a burst is open;
- MISO drops to 0 once chip select is released;
- each write address is one above the previous write in the same burst, including the wrap at the top;
- every write is followed at once by a read-back of the same address.

Only the bench scenarios can show the following:
- the values returned on MISO, with their one-byte lag in a write burst;
- the dispatch on the command byte;
- that an unknown command leaves memory untouched;
- that an aborted byte is dropped without damaging the next burst.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   // Framing phase inside one chip-select burst
   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_SKIP = 2'd3
   } phase_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [STAGES-1:0][WIDTH-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) q[i] <= RST_VAL;
      end else begin
         q[0] <= din;
         for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
      end
   end

   assign dout = q[STAGES-1];

endmodule

// File: rtl/spi_mem_shift.sv
module spi_mem_shift #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_act,
   input  logic              mosi_s,
   input  logic              tx_load,
   input  logic [WORD_W-1:0] tx_data,
   output logic              byte_done,
   output logic [WORD_W-1:0] rx_word,
   output logic              miso
);

   localparam int              CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic              sck_q;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] rx_sh;
   logic [WORD_W-1:0] tx_sh;
   logic              rise, fall;

   assign rise = sck_s & ~sck_q;
   assign fall = ~sck_s & sck_q;
   assign miso = tx_sh[WORD_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q     <= 1'b0;
         cnt       <= '0;
         rx_sh     <= '0;
         tx_sh     <= '0;
         rx_word   <= '0;
         byte_done <= 1'b0;
      end else begin
         sck_q     <= sck_s;
         byte_done <= 1'b0;
         if (!cs_act) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
         end else begin
            if (rise) begin
               rx_sh <= {rx_sh[WORD_W-2:0], mosi_s};
               if (cnt == LAST) begin
                  cnt       <= '0;
                  byte_done <= 1'b1;
                  rx_word   <= {rx_sh[WORD_W-2:0], mosi_s};
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            if (tx_load)
               tx_sh <= tx_data;
            else if (fall && cnt != '0)
               tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
   import spi_mem_pkg::*;
#(
   parameter int                WORD_W = 8,
   parameter int                ADDR_W = 8,
   parameter logic [WORD_W-1:0] CMD_RD = 'h00,
   parameter logic [WORD_W-1:0] CMD_WR = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              byte_done,
   input  logic [WORD_W-1:0] rx_word,
   input  logic [WORD_W-1:0] rf_rdata,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [WORD_W-1:0] rf_wdata,
   output logic              rf_we,
   output logic              rf_re,
   output logic              tx_load,
   output logic [WORD_W-1:0] tx_data
);

   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

   phase_t            phase;
   logic              dir_wr;
   logic [ADDR_W-1:0] ptr;
   logic              rd_pend;   // read-back after a write
   logic              cap_pend;  // read strobe in flight
   logic              ld_now;    // read data valid, load shifter
   logic              zero_ld;
   logic [ADDR_W-1:0] rx_addr;

   assign rx_addr = rx_word[ADDR_W-1:0];

   always_comb begin
      zero_ld = byte_done & cs_act &
                ((phase == PH_CMD) | (phase == PH_SKIP) |
                 ((phase == PH_ADDR) & dir_wr));
      tx_load = ld_now | zero_ld;
      tx_data = ld_now ? rf_rdata : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         dir_wr   <= 1'b0;
         ptr      <= '0;
         rd_pend  <= 1'b0;
         cap_pend <= 1'b0;
         ld_now   <= 1'b0;
         rf_addr  <= '0;
         rf_wdata <= '0;
         rf_we    <= 1'b0;
         rf_re    <= 1'b0;
      end else begin
         rf_we    <= 1'b0;
         rf_re    <= 1'b0;
         rd_pend  <= 1'b0;
         cap_pend <= 1'b0;
         ld_now   <= cap_pend & cs_act;
         if (!cs_act) begin
            phase <= PH_CMD;
         end else begin
            if (rd_pend) begin
               rf_re    <= 1'b1;
               cap_pend <= 1'b1;
               ptr      <= ptr + ONE;
            end
            if (byte_done) begin
               unique case (phase)
                  PH_CMD: begin
                     if (rx_word == CMD_RD) begin
                        phase  <= PH_ADDR;
                        dir_wr <= 1'b0;
                     end else if (rx_word == CMD_WR) begin
                        phase  <= PH_ADDR;
                        dir_wr <= 1'b1;
                     end else begin
                        phase  <= PH_SKIP;
                     end
                  end
                  PH_ADDR: begin
                     phase <= PH_DATA;
                     if (dir_wr) begin
                        ptr <= rx_addr;
                     end else begin
                        rf_re    <= 1'b1;
                        rf_addr  <= rx_addr;
                        cap_pend <= 1'b1;
                        ptr      <= rx_addr + ONE;
                     end
                  end
                  PH_DATA: begin
                     rf_addr <= ptr;
                     if (dir_wr) begin
                        rf_we    <= 1'b1;
                        rf_wdata <= rx_word;
                        rd_pend  <= 1'b1;
                     end else begin
                        rf_re    <= 1'b1;
                        cap_pend <= 1'b1;
                        ptr      <= ptr + ONE;
                     end
                  end
                  default: ;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
   parameter int                SYNC_STAGES = 2,
   parameter int                WORD_W      = 8,
   parameter int                ADDR_W      = 8,
   parameter logic [WORD_W-1:0] CMD_RD      = 'h00,
   parameter logic [WORD_W-1:0] CMD_WR      = 'h40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [WORD_W-1:0] rf_wdata,
   output logic              rf_we,
   output logic              rf_re,
   input  logic [WORD_W-1:0] rf_rdata
);

   if (SYNC_STAGES < 0 || WORD_W < 2 || ADDR_W < 1 || ADDR_W > WORD_W ||
       CMD_RD == CMD_WR) begin : g_bad_cfg
      $error("spi_mem_slave: illegal parameter combination");
   end

   logic              sck_s, cs_n_s, mosi_s, cs_act;
   logic              byte_done, tx_load;
   logic [WORD_W-1:0] rx_word, tx_data;

   // Variant: zero stages for an SCK already in the system domain
   if (SYNC_STAGES == 0) begin : g_direct
      assign {sck_s, cs_n_s, mosi_s} = {spi_sck, spi_cs_n, spi_mosi};
   end else begin : g_sync
      logic [2:0] sync_bus;
      spi_mem_sync #(
         .WIDTH   (3),
         .STAGES  (SYNC_STAGES),
         .RST_VAL (3'b010)
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   ({spi_sck, spi_cs_n, spi_mosi}),
         .dout  (sync_bus)
      );
      assign {sck_s, cs_n_s, mosi_s} = sync_bus;
   end

   assign cs_act = ~cs_n_s;

   spi_mem_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .cs_act    (cs_act),
      .mosi_s    (mosi_s),
      .tx_load   (tx_load),
      .tx_data   (tx_data),
      .byte_done (byte_done),
      .rx_word   (rx_word),
      .miso      (spi_miso)
   );

   spi_mem_ctrl #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .CMD_RD (CMD_RD),
      .CMD_WR (CMD_WR)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .byte_done (byte_done),
      .rx_word   (rx_word),
      .rf_rdata  (rf_rdata),
      .rf_addr   (rf_addr),
      .rf_wdata  (rf_wdata),
      .rf_we     (rf_we),
      .rf_re     (rf_re),
      .tx_load   (tx_load),
      .tx_data   (tx_data)
   );

endmodule

// File: rtl/spi_mem_checker.sv
module spi_mem_checker #(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_act,
   input logic              miso,
   input logic              rf_we,
   input logic              rf_re,
   input logic [ADDR_W-1:0] rf_addr
);

   logic [ADDR_W-1:0] last_wa;
   logic              have_wa;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_wa <= '0;
         have_wa <= 1'b0;
      end else if (!cs_act) begin
         have_wa <= 1'b0;
      end else if (rf_we) begin
         last_wa <= rf_addr;
         have_wa <= 1'b1;
      end
   end

   a_r10_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);
   a_r10_re_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rf_re |=> !rf_re);
   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rf_we && rf_re));
   a_r11_we_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> $past(cs_act));
   a_r11_re_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      rf_re |-> $past(cs_act));
   a_r11_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso);
   // R7 also covered: the +1 step is modulo the address width
   a_r3_write_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && have_wa) |-> rf_addr == last_wa + ADDR_W'(1));
   a_r5_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_we && cs_act) |=> (rf_re && rf_addr == $past(rf_addr)));

endmodule

bind spi_mem_slave spi_mem_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_act  (cs_act),
   .miso    (spi_miso),
   .rf_we   (rf_we),
   .rf_re   (rf_re),
   .rf_addr (rf_addr)
);

// File: tb/test_spi_mem_slave.sv
`timescale 1ns/1ps
module test_spi_mem_slave;

   localparam int H = 8;            // SCK half period in system clocks
   localparam logic [7:0] XM = 8'h5A; // register-file output transform

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       miso;
   logic [7:0] rf_addr, rf_wdata, rf_rdata;
   logic       rf_we, rf_re;

   int nchk = 0, nerr = 0, nwe = 0;
   bit done = 1'b0;
   logic [7:0] mem [256];
   logic [7:0] ex  [256];

   always #4 clk = ~clk;

   spi_mem_slave i_spi_mem_slave (
      .clk (clk), .rst_n (rst_n), .spi_sck (sck), .spi_cs_n (cs_n),
      .spi_mosi (mosi), .spi_miso (miso), .rf_addr (rf_addr),
      .rf_wdata (rf_wdata), .rf_we (rf_we), .rf_re (rf_re),
      .rf_rdata (rf_rdata)
   );

   // Register-file model: output of an address is its stored value ^ XM
   always @(posedge clk) begin
      if (rf_we) begin
         mem[rf_addr] <= rf_wdata;
         nwe <= nwe + 1;
      end
      if (rf_re) rf_rdata <= mem[rf_addr] ^ XM;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xbits(input logic [7:0] b, input int nb, output logic [7:0] r);
      r = '0;
      for (int i = 7; i > 7 - nb; i--) begin
         mosi = b[i];
         repeat (H) @(negedge clk);
         sck = 1'b1;
         r[i] = miso;
         repeat (H) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
      xbits(b, 8, r);
   endtask

   task automatic cs_low;
      repeat (H) @(negedge clk);
      cs_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic cs_high;
      repeat (H) @(negedge clk);
      cs_n = 1'b1;
      repeat (3 * H) @(negedge clk);
   endtask

   task automatic wr_burst(input logic [7:0] a, input int n, input int seed, input string tag);
      logic [7:0] r, d, prev;
      cs_low();
      xbyte(8'h40, r);
      xbyte(a, r);
      for (int k = 0; k < n; k++) begin
         d = 8'(k * 37 + seed);
         xbyte(d, r);
         if (k == 0) chk({tag, " R5 first byte"}, r, 8'h00);
         else        chk({tag, " R5 lagged return"}, r, prev ^ XM);
         ex[8'(a + k)] = d;
         prev = d;
      end
      cs_high();
   endtask

   task automatic rd_burst(input logic [7:0] a, input int n, input string tag);
      logic [7:0] r;
      cs_low();
      xbyte(8'h00, r);
      chk({tag, " R6 cmd byte return"}, r, 8'h00);
      xbyte(a, r);
      chk({tag, " R6 addr byte return"}, r, 8'h00);
      for (int k = 0; k < n; k++) begin
         xbyte(8'hFF, r);
         chk({tag, " R1/R2/R3/R6 read data"}, r, ex[8'(a + k)] ^ XM);
      end
      cs_high();
   endtask

   initial begin
      logic [7:0] r;
      int w0;
      for (int i = 0; i < 256; i++) begin mem[i] = '0; ex[i] = '0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R11 reset miso", miso, 0);
      chk("R11 reset we", rf_we, 0);
      chk("R11 reset re", rf_re, 0);

      // Write burst, then read back (R4 strobe count)
      w0 = nwe;
      wr_burst(8'h10, 6, 5, "S1");
      chk("R4 one strobe per byte", nwe - w0, 6);
      rd_burst(8'h10, 6, "S2");

      // Wrap at the top of the address space
      wr_burst(8'hFE, 4, 90, "R7 wr");
      rd_burst(8'hFD, 5, "R7 rd");

      // Unknown command is ignored
      w0 = nwe;
      cs_low();
      xbyte(8'h33, r); chk("R8 miso cmd", r, 0);
      xbyte(8'h10, r); chk("R8 miso addr", r, 0);
      for (int k = 0; k < 3; k++) begin
         xbyte(8'hEE, r);
         chk("R8 miso data", r, 0);
      end
      cs_high();
      chk("R8 no writes", nwe - w0, 0);
      rd_burst(8'h10, 3, "R8 unchanged");

      // Abort mid-byte
      w0 = nwe;
      cs_low();
      xbyte(8'h40, r);
      xbyte(8'h20, r);
      xbyte(8'h77, r);
      xbits(8'h99, 4, r);
      cs_high();
      ex[8'h20] = 8'h77;
      chk("R9 only full byte written", nwe - w0, 1);
      rd_burst(8'h20, 2, "R9 reframe");

      // Full sweep with wrap
      wr_burst(8'h80, 256, 11, "SW");
      rd_burst(8'h80, 256, "SW R7");

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog R4 actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule